// File: doc/BRIEF.md
# Port Control Set/Clear Register

This block is the per-port control and status word of a storage host port, seen over a plain 32-bit register write/read bus. Software never writes the control word directly. One address turns on every control bit written as a one, and a second address turns off every control bit written as a one. Bits written as zero stay as they were. This lets independent pieces of software change single controls without a read-modify-write.

A read at the set address returns the control bits merged with live status. The word holds these controls: port reset, device reset, port initialize, interrupt write-one-to-clear mode, resume, 32-bit activation and port-multiplier enable. Port reset, device reset and initialize clear themselves once an internal timer reaches a parameter cycle count. Bit 31 is a read-only "port ready" flag, driven by the block from the state of those three bits.

Top module: `port_ctl_top`

## Requirements
- R1: After hardware reset the set address reads 0x00000001: port reset (bit 0) is 1, every other control bit is 0 and port ready (bit 31) is 0.
- R2: A write to offset 0x1000 (set address) sets each writable control bit that is one in the write data; all other control bits keep their value. Writable bits are 0 port reset, 1 device reset, 2 initialize, 3 interrupt write-one-to-clear mode, 6 resume, 10 32-bit activation, 13 port-multiplier enable.
- R3: A write to offset 0x1004 (clear address) clears each writable control bit that is one in the write data; bits written as zero keep their value.
- R4: Bit 31 and all bits outside the writable set ignore writes to both addresses; the non-writable positions other than bit 31 always read 0.
- R5: Device reset (bit 1), once set, reads 1 for exactly RST_CYCLES clock cycles and then clears itself.
- R6: Port reset (bit 0) clears itself after RST_CYCLES cycles, and a write of bit 0 to the clear address clears it at the edge of that write.
- R7: Initialize (bit 2), once set, reads 1 for exactly INIT_CYCLES cycles and then clears itself.
- R8: Port ready reads 0 in the cycle after any of bits 0, 1 or 2 is 1, and reads 1 in the cycle after all three are 0.
- R9: Writes to any address other than the set and clear addresses change nothing, and reads at any other address return 0.
- R10: Each write takes effect at the clock edge of its write strobe, so a set followed in a later cycle by a clear of the same bit leaves that bit 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Byte offset within the port register window |
| busWrEn | input | 1 | Write strobe, one write per asserted cycle |
| busWrData | input | 32 | Write data |
| busRdData | output | 32 | Read data for busAddr, combinational |

## Verification
The bench builds the block with RST_CYCLES at 5 and INIT_CYCLES at 3. With those values, every cycle of each self-clearing window and the ready flag's one-cycle lag can be checked around the clear point within a few dozen cycles. All sixteen combinations of the four persistent controls are swept through set and clear writes that also carry bit 31 and unused bits. Port reset is released by software both right after reset and partway through its timer.

// File: rtl/port_ctl_pkg.sv
package port_ctl_pkg;
  localparam int CTL_W      = 32;
  localparam int BIT_PRST   = 0;
  localparam int BIT_DRST   = 1;
  localparam int BIT_INIT   = 2;
  localparam int BIT_WOC    = 3;
  localparam int BIT_RESUME = 6;
  localparam int BIT_ACT32  = 10;
  localparam int BIT_PMEN   = 13;
  localparam int BIT_READY  = 31;

  localparam logic [CTL_W-1:0] BUSY_MASK =
    (CTL_W'(1) << BIT_PRST) | (CTL_W'(1) << BIT_DRST) | (CTL_W'(1) << BIT_INIT);
  localparam logic [CTL_W-1:0] PERSIST_MASK =
    (CTL_W'(1) << BIT_WOC) | (CTL_W'(1) << BIT_RESUME) |
    (CTL_W'(1) << BIT_ACT32) | (CTL_W'(1) << BIT_PMEN);
  localparam logic [CTL_W-1:0] WR_MASK = BUSY_MASK | PERSIST_MASK;

  typedef struct packed {
    logic             setEn;
    logic             clrEn;
    logic [CTL_W-1:0] bits;
  } ctlStrobe_t;
endpackage

// File: rtl/port_ctl_decode.sv
module port_ctl_decode
  import port_ctl_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int SET_OFS = 'h1000,
  parameter int CLR_OFS = 'h1004
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [CTL_W-1:0]  busWrData,
  output ctlStrobe_t        strobe,
  output logic              rdSel
);
  localparam logic [ADDR_W-1:0] SET_A = ADDR_W'(SET_OFS);
  localparam logic [ADDR_W-1:0] CLR_A = ADDR_W'(CLR_OFS);

  logic hitSet;
  logic hitClr;

  always_comb begin
    hitSet       = (busAddr == SET_A);
    hitClr       = (busAddr == CLR_A);
    strobe.setEn = busWrEn && hitSet;
    strobe.clrEn = busWrEn && hitClr;
    strobe.bits  = busWrData & WR_MASK;
    rdSel        = hitSet;
  end
endmodule

// File: rtl/port_ctl_datapath.sv
module port_ctl_datapath
  import port_ctl_pkg::*;
#(
  parameter int RST_CYCLES  = 16,
  parameter int INIT_CYCLES = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  ctlStrobe_t       strobe,
  output logic [CTL_W-1:0] ctlBits,
  output logic             portReady
);
  localparam int NUM_TIMED = 3;
  localparam int MAX_LIM   = (RST_CYCLES > INIT_CYCLES) ? RST_CYCLES : INIT_CYCLES;
  localparam int CNT_W     = (MAX_LIM < 2) ? 1 : $clog2(MAX_LIM + 1);

  logic [CTL_W-1:0]     ctlQ;
  logic [CTL_W-1:0]     ctlNext;
  logic [CTL_W-1:0]     expireVec;
  logic [NUM_TIMED-1:0] expireBit;
  logic                 readyQ;

  for (genvar g = 0; g < NUM_TIMED; g++) begin : gTimer
    localparam int BITPOS = (g == 0) ? BIT_PRST : (g == 1) ? BIT_DRST : BIT_INIT;
    localparam int LIMIT  = (g == 2) ? INIT_CYCLES : RST_CYCLES;
    logic [CNT_W-1:0] cnt;

    assign expireBit[g] = ctlQ[BITPOS] && (cnt == CNT_W'(LIMIT - 1));

    always_ff @(posedge clk) begin
      if (!rstN)                           cnt <= '0;
      else if (!ctlQ[BITPOS] || expireBit[g]) cnt <= '0;
      else                                 cnt <= cnt + 1'b1;
    end
  end

  always_comb begin
    expireVec           = '0;
    expireVec[BIT_PRST] = expireBit[0];
    expireVec[BIT_DRST] = expireBit[1];
    expireVec[BIT_INIT] = expireBit[2];
    ctlNext = ctlQ & ~expireVec;
    if (strobe.clrEn) ctlNext = ctlNext & ~strobe.bits;
    if (strobe.setEn) ctlNext = ctlNext | strobe.bits;
    ctlNext = ctlNext & WR_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      ctlQ   <= CTL_W'(1) << BIT_PRST;
      readyQ <= 1'b0;
    end else begin
      ctlQ   <= ctlNext;
      readyQ <= ~|(ctlQ & BUSY_MASK);
    end
  end

  assign ctlBits   = ctlQ;
  assign portReady = readyQ;
endmodule

// File: rtl/port_ctl_top.sv
module port_ctl_top
  import port_ctl_pkg::*;
#(
  parameter int ADDR_W      = 13,
  parameter int SET_OFS     = 'h1000,
  parameter int CLR_OFS     = 'h1004,
  parameter int RST_CYCLES  = 16,
  parameter int INIT_CYCLES = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWrEn,
  input  logic [31:0]       busWrData,
  output logic [31:0]       busRdData
);
  ctlStrobe_t       strobe;
  logic             rdSel;
  logic [CTL_W-1:0] ctlBits;
  logic             portReady;

  port_ctl_decode #(.ADDR_W(ADDR_W), .SET_OFS(SET_OFS), .CLR_OFS(CLR_OFS)) uDecode (
    .busAddr(busAddr), .busWrEn(busWrEn), .busWrData(busWrData),
    .strobe(strobe), .rdSel(rdSel)
  );

  port_ctl_datapath #(.RST_CYCLES(RST_CYCLES), .INIT_CYCLES(INIT_CYCLES)) uPath (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .ctlBits(ctlBits), .portReady(portReady)
  );

  always_comb begin
    busRdData = '0;
    if (rdSel) begin
      busRdData            = ctlBits;
      busRdData[BIT_READY] = portReady;
    end
  end
endmodule

// File: rtl/port_ctl_checker.sv
module port_ctl_checker
  import port_ctl_pkg::*;
#(
  parameter int ADDR_W     = 13,
  parameter int SET_OFS    = 'h1000,
  parameter int CLR_OFS    = 'h1004,
  parameter int RST_CYCLES = 16
) (
  input logic              clk,
  input logic              rstN,
  input logic [ADDR_W-1:0] busAddr,
  input logic              busWrEn,
  input logic [31:0]       busWrData,
  input logic [CTL_W-1:0]  ctlBits,
  input logic              portReady
);
  logic wrSet;
  logic wrClr;
  logic wrOther;
  logic anyBusy;
  int   dRstHigh;

  assign wrSet   = busWrEn && (busAddr == ADDR_W'(SET_OFS));
  assign wrClr   = busWrEn && (busAddr == ADDR_W'(CLR_OFS));
  assign wrOther = busWrEn && !wrSet && !wrClr;
  assign anyBusy = ctlBits[BIT_PRST] || ctlBits[BIT_DRST] || ctlBits[BIT_INIT];

  always_ff @(posedge clk) begin
    if (!rstN || !ctlBits[BIT_DRST] || (wrSet && busWrData[BIT_DRST])) dRstHigh <= 0;
    else dRstHigh <= dRstHigh + 1;
  end

  AST_SET_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    (wrSet && busWrData[BIT_PMEN]) |=> ctlBits[BIT_PMEN]); // R2

  AST_CLR_TAKES: assert property (@(posedge clk) disable iff (!rstN)
    (wrClr && busWrData[BIT_WOC] && !busWrData[BIT_PMEN]) |=> !ctlBits[BIT_WOC]); // R3

  AST_DRST_WINDOW: assert property (@(posedge clk) disable iff (!rstN)
    ctlBits[BIT_DRST] |-> (dRstHigh < RST_CYCLES)); // R5

  AST_READY_DROP: assert property (@(posedge clk) disable iff (!rstN)
    anyBusy |=> !portReady); // R8

  AST_READY_RISE: assert property (@(posedge clk) disable iff (!rstN)
    !anyBusy |=> portReady); // R8

  AST_OTHER_ADDR: assert property (@(posedge clk) disable iff (!rstN)
    wrOther |=> $stable(ctlBits & PERSIST_MASK)); // R9
endmodule

bind port_ctl_top port_ctl_checker #(
  .ADDR_W(ADDR_W), .SET_OFS(SET_OFS), .CLR_OFS(CLR_OFS), .RST_CYCLES(RST_CYCLES)
) uChk (
  .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
  .busWrData(busWrData), .ctlBits(ctlBits), .portReady(portReady)
);

// File: tb/port_ctl_top_test.sv
module port_ctl_top_test;
  localparam int ADDR_W  = 13;
  localparam int RST_N   = 5;
  localparam int INIT_N  = 3;
  localparam logic [ADDR_W-1:0] A_SET = 13'h1000;
  localparam logic [ADDR_W-1:0] A_CLR = 13'h1004;
  localparam logic [31:0] PMASK = 32'h0000_2448;
  localparam logic [31:0] JUNK  = 32'hF000_0130;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic [ADDR_W-1:0] busAddr = A_SET;
  logic              busWrEn = 1'b0;
  logic [31:0]       busWrData = '0;
  logic [31:0]       busRdData;

  int  numChecks = 0;
  int  numFails  = 0;
  bit  finished  = 0;
  logic [31:0] persist = '0;
  logic [31:0] rd;

  port_ctl_top #(.ADDR_W(ADDR_W), .RST_CYCLES(RST_N), .INIT_CYCLES(INIT_N)) uut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrEn(busWrEn),
    .busWrData(busWrData), .busRdData(busRdData)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    numChecks++;
    if (act !== exp) begin
      numFails++;
      $display("FAIL %s: actual %08h expected %08h", req, act, exp);
    end
  endtask

  task automatic writeReg(input logic [ADDR_W-1:0] a, input logic [31:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    busWrEn = 1'b0; busAddr = A_SET;
  endtask

  task automatic readReg(input logic [ADDR_W-1:0] a, output logic [31:0] v);
    busAddr = a;
    #1;
    v = busRdData;
    busAddr = A_SET;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", numChecks, numFails);
    $finish;
  endtask

  task automatic runTimed(input int pos, input int lim, input string req);
    logic [31:0] v;
    writeReg(A_SET, 32'(1) << pos);
    for (int k = 0; k <= lim + 1; k++) begin
      bit expBit;
      bit expRdy;
      if (k > 0) idle(1);
      expBit = (k < lim);
      expRdy = (k == 0) || ((k - 1) >= lim);
      readReg(A_SET, v);
      check(req, v, persist | (32'(expBit) << pos) | (32'(expRdy) << 31));
    end
  endtask

  initial begin
    #(200000 * 8);
    if (!finished) begin
      numChecks++;
      numFails++;
      $display("FAIL watchdog: actual hung expected done");
      finishRun();
    end
  end

  initial begin
    logic [31:0] v;
    idle(3);
    rstN = 1'b1;
    // R1 reset state
    readReg(A_SET, v);
    check("R1", v, 32'h0000_0001);
    // R6 software release of port reset, R8 ready lag
    writeReg(A_CLR, 32'h0000_0001);
    readReg(A_SET, v);
    check("R6", v, 32'h0000_0000);
    idle(1);
    readReg(A_SET, v);
    check("R8", v, 32'h8000_0000);

    // R2 R3 R4 R10 sweep of persistent controls
    for (int c = 0; c < 16; c++) begin
      logic [31:0] mSet;
      logic [31:0] mClr;
      mSet = ({31'b0, c[0]} << 3) | ({31'b0, c[1]} << 6) |
             ({31'b0, c[2]} << 10) | ({31'b0, c[3]} << 13);
      mClr = ({31'b0, c[1]} << 3) | ({31'b0, c[3]} << 6) | ({31'b0, c[0]} << 13);
      writeReg(A_SET, mSet | JUNK);
      persist = persist | mSet;
      readReg(A_SET, v);
      check("R2", v, persist | 32'h8000_0000);
      writeReg(A_CLR, mClr | JUNK);
      persist = persist & ~mClr;
      readReg(A_SET, v);
      check("R3", v, persist | 32'h8000_0000);
      if ((v & ~PMASK & ~32'h8000_0000) != 0) check("R4", v & ~PMASK, 32'h8000_0000);
    end
    // R10 set then clear same bit in later cycle
    writeReg(A_SET, 32'h0000_0040);
    writeReg(A_CLR, 32'h0000_0040);
    persist = persist & ~32'h0000_0040;
    readReg(A_SET, v);
    check("R10", v, persist | 32'h8000_0000);
    // R4 write to bit 31 alone
    writeReg(A_CLR, 32'h8000_0000);
    readReg(A_SET, v);
    check("R4", v, persist | 32'h8000_0000);

    // R9 other addresses
    writeReg(13'h1008, 32'hFFFF_FFFF);
    writeReg(13'h0000, 32'hFFFF_FFFF);
    idle(1);
    readReg(A_SET, v);
    check("R9", v, persist | 32'h8000_0000);
    readReg(A_CLR, v);
    check("R9", v, 32'h0000_0000);
    readReg(13'h1008, v);
    check("R9", v, 32'h0000_0000);

    // R5 R6 R7 self-clearing windows
    runTimed(1, RST_N, "R5");
    idle(2);
    runTimed(0, RST_N, "R6");
    idle(2);
    runTimed(2, INIT_N, "R7");
    idle(2);

    // R6 software clear partway through the port reset timer
    writeReg(A_SET, 32'h0000_0001);
    idle(2);
    writeReg(A_CLR, 32'h0000_0001);
    readReg(A_SET, v);
    check("R6", v, persist);
    idle(1);
    readReg(A_SET, v);
    check("R8", v, persist | 32'h8000_0000);

    finished = 1;
    finishRun();
  end
endmodule